// File: doc/BRIEF.md
# Least-Recently-Granted Bus Arbiter

This block shares one bus among five agents: a local host-side controller and four external devices. It keeps a full priority list of all five agents. A new grant goes to the requesting agent that is highest in that list. When the granted agent reports that its transfer has finished, that agent drops to the bottom of the list. The other agents move up to fill the gap and keep their relative order, so an agent that has waited longer is never overtaken.

Each agent has one request input and one grant output. The granted agent holds the bus until the transfer-done pulse arrives. After that pulse the bus is idle for one cycle, and the arbiter then makes a new decision. When the bus is idle and nobody is requesting, a bridge-mode input selects what happens: with the input set, the grant is parked on the local controller; with it clear, no grant is driven.

Top module: `lrg_bus_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, no grant is driven. The list starts as host, device 0, device 1, device 2, device 3. Agent index k maps to bit k of `req_i` and `gnt_o`: bit 0 is the host and bit k+1 is device k.
- R2: When no transfer grant is active and at least one request is asserted, the arbiter grants the requesting agent that is highest in the list. The grant appears one clock after the request is sampled.
- R3: At most one bit of `gnt_o` is ever high.
- R4: A transfer grant stays unchanged, whatever the requests do, until `xfer_done_i` is sampled high.
- R5: When `xfer_done_i` is sampled high during a transfer grant, the granted agent moves to the bottom of the list and the other agents keep their relative order. Example: host>d0>d2>d3>d1 becomes d0>d2>d3>d1>host after the host is serviced. Servicing d3 from d0>d2>d3>d1>host gives d0>d2>d1>host>d3.
- R6: In the clock after the done pulse, `gnt_o` is all zero. A new decision is made in the cycle after that.
- R7: The list is always a permutation of the five agents, so under continuous requests from all agents each agent is granted once in every five grants.
- R8: With `host_bridge_i` high, when no transfer grant is active and no request is asserted, the grant parks on the host (`gnt_o` = 00001). A parked grant does not count as a transfer.
- R9: With `host_bridge_i` low, when no transfer grant is active and no request is asserted, `gnt_o` is all zero.
- R10: A `xfer_done_i` pulse while no transfer grant is active, including while the bus is parked, leaves the list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Bus requests; bit 0 host, bit k+1 device k |
| xfer_done_i | input | 1 | One-cycle pulse: the current transfer has finished |
| host_bridge_i | input | 1 | Host bridge mode; parks the idle bus on the host |
| gnt_o | output | 5 | Registered one-hot grant, same bit mapping as req_i |

## Verification
The assertions check the following on every cycle:
- the grant is never more than one-hot;
- a transfer grant is held until the done pulse;
- the bus goes idle for one cycle after a done pulse;
- parking happens only in bridge mode;
- the stored list stays a permutation;
- a serviced agent lands at the bottom;
- the list changes only on a serviced done pulse.

Only the bench's scenarios can show that the relative order of the agents that were not serviced is kept exactly. Its reference model holds the list as a queue, and the bench compares grant sequences against that model. The documented reorder examples, and done pulses sent while the bus is parked, are driven as explicit scenarios.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  parameter int unsigned NUM_AGENTS = 5;
  localparam int unsigned ID_W = $clog2(NUM_AGENTS);
  localparam int unsigned HOST_IDX = 0;
  typedef logic [ID_W-1:0] agent_id_t;
endpackage

// File: rtl/lrg_order_list.sv
module lrg_order_list #(
  parameter int unsigned N  = lrg_pkg::NUM_AGENTS,
  parameter int unsigned IW = lrg_pkg::ID_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd_en,
  input  logic [IW-1:0]          upd_id,
  output logic [N-1:0][IW-1:0]   order_o
);
  localparam int unsigned SLOTS = 1 << IW;

  logic [N-1:0][IW-1:0] order_q;
  logic [N-1:0][IW-1:0] order_nxt;
  logic [IW-1:0]        hit_pos;

  // Find the slot that currently holds the serviced agent.
  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < N; i++) begin
      if (order_q[i] == upd_id) hit_pos = IW'(i);
    end
  end

  // Slots at or below the serviced one shift up; the serviced agent goes to the bottom.
  generate
    for (genvar g = 0; g < N - 1; g++) begin : g_shift
      assign order_nxt[g] = (upd_en && (IW'(g) >= hit_pos)) ? order_q[g+1] : order_q[g];
    end
  endgenerate
  assign order_nxt[N-1] = upd_en ? upd_id : order_q[N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) order_q[i] <= IW'(i);
    end else begin
      order_q <= order_nxt;
    end
  end

  assign order_o = order_q;

  logic [SLOTS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) seen[order_q[i]] = 1'b1;
  end

  AST_ORDER_PERM: assert property (@(posedge clk) disable iff (rst)
    (&seen[N-1:0])); // R7
  AST_SERVED_LAST: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (order_q[N-1] == $past(upd_id))); // R5
  AST_ORDER_STILL: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(order_q)); // R10
endmodule

// File: rtl/lrg_pick.sv
module lrg_pick #(
  parameter int unsigned N  = lrg_pkg::NUM_AGENTS,
  parameter int unsigned IW = lrg_pkg::ID_W
) (
  input  logic [N-1:0][IW-1:0] order_i,
  input  logic [N-1:0]         req_i,
  output logic                 hit_o,
  output logic [IW-1:0]        win_o
);
  localparam int unsigned SLOTS = 1 << IW;

  logic [SLOTS-1:0] req_x;
  assign req_x = {{(SLOTS-N){1'b0}}, req_i};

  // Scan from the bottom of the list upward so the highest-ordered requester wins.
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_x[order_i[i]]) begin
        hit_o = 1'b1;
        win_o = order_i[i];
      end
    end
  end
endmodule

// File: rtl/lrg_grant_ctrl.sv
module lrg_grant_ctrl #(
  parameter int unsigned N    = lrg_pkg::NUM_AGENTS,
  parameter int unsigned IW   = lrg_pkg::ID_W,
  parameter int unsigned HOST = lrg_pkg::HOST_IDX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          hit_i,
  input  logic [IW-1:0] win_i,
  input  logic          done_i,
  input  logic          park_en_i,
  output logic [N-1:0]  gnt_o,
  output logic          upd_en_o,
  output logic [IW-1:0] upd_id_o
);
  logic [N-1:0]  gnt_q;
  logic          busy_q;
  logic [IW-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (busy_q) begin
      if (done_i) begin
        gnt_q  <= '0;
        busy_q <= 1'b0;
      end
    end else if (hit_i) begin
      gnt_q  <= N'(1) << win_i;
      busy_q <= 1'b1;
      cur_q  <= win_i;
    end else if (park_en_i) begin
      gnt_q  <= N'(1) << HOST;
    end else begin
      gnt_q  <= '0;
    end
  end

  assign gnt_o    = gnt_q;
  assign upd_en_o = busy_q & done_i;
  assign upd_id_o = cur_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R3
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && (|req_i)) |=> (busy_q && (|(gnt_q & $past(req_i))))); // R2
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_i) |=> ($stable(gnt_q) && busy_q)); // R4
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && done_i) |=> (gnt_q == '0)); // R6
  AST_PARK_HOST: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !(|req_i) && park_en_i) |=> (gnt_q == (N'(1) << HOST))); // R8
  AST_NO_PARK: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !(|req_i) && !park_en_i) |=> (gnt_q == '0)); // R9
endmodule

// File: rtl/lrg_bus_arbiter.sv
module lrg_bus_arbiter #(
  parameter int unsigned N  = lrg_pkg::NUM_AGENTS,
  parameter int unsigned IW = lrg_pkg::ID_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         xfer_done_i,
  input  logic         host_bridge_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0][IW-1:0] order;
  logic                 hit;
  logic [IW-1:0]        win;
  logic                 upd_en;
  logic [IW-1:0]        upd_id;

  lrg_order_list #(.N(N), .IW(IW)) u_order (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_id  (upd_id),
    .order_o (order)
  );

  lrg_pick #(.N(N), .IW(IW)) u_pick (
    .order_i (order),
    .req_i   (req_i),
    .hit_o   (hit),
    .win_o   (win)
  );

  lrg_grant_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .hit_i     (hit),
    .win_i     (win),
    .done_i    (xfer_done_i),
    .park_en_i (host_bridge_i),
    .gnt_o     (gnt_o),
    .upd_en_o  (upd_en),
    .upd_id_o  (upd_id)
  );
endmodule

// File: tb/lrg_bus_arbiter_tb.sv
module lrg_bus_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] req = '0;
  logic       done = 1'b0;
  logic       hb = 1'b0;
  logic [4:0] gnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state: value of the grant after the next rising edge.
  int         m_ord[$];
  logic [4:0] m_gnt;
  bit         m_busy;
  int         m_cur;

  always #4 clk = ~clk;

  lrg_bus_arbiter u_dut (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req),
    .xfer_done_i   (done),
    .host_bridge_i (hb),
    .gnt_o         (gnt)
  );

  task automatic model_next();
    if (rst) begin
      m_ord = '{0, 1, 2, 3, 4};
      m_gnt = '0;
      m_busy = 0;
      m_cur = 0;
    end else if (m_busy) begin
      if (done) begin
        for (int i = 0; i < m_ord.size(); i++) begin
          if (m_ord[i] == m_cur) begin
            m_ord.delete(i);
            break;
          end
        end
        m_ord.push_back(m_cur);
        m_gnt = '0;
        m_busy = 0;
      end
    end else begin
      int w;
      w = -1;
      foreach (m_ord[i]) begin
        if (w < 0 && req[m_ord[i]]) w = m_ord[i];
      end
      if (w >= 0) begin
        m_gnt = 5'(1) << w;
        m_busy = 1;
        m_cur = w;
      end else if (hb) begin
        m_gnt = 5'b00001;
      end else begin
        m_gnt = '0;
      end
    end
  endtask

  task automatic check(input string tag);
    n_cmp++;
    if (gnt !== m_gnt) begin
      n_bad++;
      $display("FAIL %s: gnt_o=%b expected %b", tag, gnt, m_gnt);
    end
  endtask

  task automatic step(input logic r_rst, input logic [4:0] r, input logic d,
                      input logic h, input string tag);
    @(negedge clk);
    check(tag);
    rst = r_rst; req = r; done = d; hb = h;
    model_next();
  endtask

  task automatic expect_gnt(input logic [4:0] exp, input string tag);
    @(negedge clk);
    n_cmp++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt_o=%b expected %b", tag, gnt, exp);
    end
  endtask

  // Request one agent, hold it, then finish its transfer.
  task automatic serve(input int a, input string tag);
    step(0, 5'(1) << a, 0, 0, tag);
    step(0, 5'(1) << a, 0, 0, tag);
    step(0, 5'b11111, 0, 0, {tag, "/R4"});
    step(0, 5'b00000, 1, 0, tag);
    step(0, 5'b00000, 0, 0, "R6");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    m_ord = '{0, 1, 2, 3, 4};
    m_gnt = '0; m_busy = 0; m_cur = 0;
    repeat (3) step(1, 5'b11111, 0, 1, "R1");
    step(0, 5'b00000, 0, 0, "R1");
    step(0, 5'b00000, 0, 0, "R9");
    expect_gnt(5'b00000, "R1");

    // R2: all requesting out of reset -> host first
    step(0, 5'b11111, 0, 0, "R2");
    expect_gnt(5'b00001, "R2");
    step(0, 5'b11110, 1, 0, "R2");
    step(0, 5'b00000, 0, 0, "R6");
    expect_gnt(5'b00000, "R6");
    step(1, 5'b00000, 0, 0, "R1");
    step(0, 5'b00000, 0, 0, "R1");

    // R5: documented sequence: serve d1, host, d3 -> order d0,d2,d1,host,d3
    serve(2, "R5");
    serve(0, "R5");
    serve(4, "R5");
    begin
      int exp_seq[5] = '{1, 3, 2, 0, 4};
      for (int k = 0; k < 5; k++) begin
        step(0, 5'b11111, 0, 0, "R7");
        expect_gnt(5'(1) << exp_seq[k], "R5");
        step(0, 5'b11111, 1, 0, "R7");
        step(0, 5'b00000, 0, 0, "R6");
      end
    end

    // R8 parking and R10 done while parked
    step(0, 5'b00000, 0, 1, "R8");
    step(0, 5'b00000, 1, 1, "R10");
    expect_gnt(5'b00001, "R8");
    step(0, 5'b00000, 1, 1, "R10");
    step(0, 5'b01000, 0, 1, "R10");
    step(0, 5'b00000, 1, 1, "R2");
    step(0, 5'b00000, 0, 0, "R9");
    step(0, 5'b00000, 1, 0, "R10");
    expect_gnt(5'b00000, "R9");
    step(0, 5'b00000, 0, 0, "R9");

    // Mixed pseudo-random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      logic [4:0] r;
      logic d, h;
      r = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) r = '0;
      d = ($urandom_range(0, 2) == 0);
      h = ($urandom_range(0, 1) == 0);
      step(0, r, d, h, "R2/R3/R4/R5");
    end
    step(0, 5'b00000, 0, 0, "R5");
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
    $finish;
  end
endmodule